// File: doc/BRIEF.md
# Rotated-Byte Immediate Encoder

The block decides whether a 32-bit constant fits a compact 12-bit immediate field. In that field an 8-bit byte is rotated right by an even number of bit positions, and the rotate amount is stored as a 4-bit count of bit pairs. When an encoding exists, the block returns the byte and the rotate count. When none exists, it raises an invalid flag, and the surrounding logic can then choose a slower way to build the constant.

The search is iterative. A start pulse latches the constant, and one candidate rotate count is tried per cycle, from zero upward. The first count that works is reported, so the encoding with the smallest rotation wins. A one-cycle done pulse closes the search. The result stays on the outputs until the next accepted start. A separate combinational decoder expands any 12-bit field back into the 32-bit value it stands for.

Top module: `rot_imm_encoder`

## Requirements
- R1: A start pulse while the block is not busy latches the constant. Busy is high from the next cycle on, and valid and invalid both read 0 from that cycle.
- R2: On a valid result, rotating the zero-extended byte `imm_n_o` right by 2×`imm_rot_o` bits gives back the latched constant (for example 0x06000000 gives byte 6 with rotate count 4, an 8-bit rotation).
- R3: When several rotate counts work, the smallest one is reported (0xC0000000 gives byte 3 with count 1, and 3 gives byte 3 with count 0).
- R4: The constant 0 encodes as byte 0 with rotate count 0.
- R5: A constant with no encoding raises invalid, with byte and count outputs at 0. Examples: 511, 370 and 0x06010000. By contrast, 256 gives byte 1 with count 12, and 484 gives byte 121 with count 15.
- R6: Done is high for exactly one cycle. Counting busy cycles from start, a match at count r takes r+1 cycles and an invalid result takes 16.
- R7: Valid and invalid are never high together. They hold steady, together with the byte and count outputs, from done until the next accepted start.
- R8: A start pulse while busy is ignored. The search in progress finishes on its own constant and produces a single done.
- R9: The decoder output `dec_value_o` equals `dec_field_i[7:0]`, zero-extended, rotated right by 2×`dec_field_i[11:8]` bits, in the same cycle.
- R10: After reset, busy, done, valid and invalid are 0, and the byte and count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a search on `value_i` when not busy |
| value_i | input | 32 | Constant to encode |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| valid_o | output | 1 | Last search found an encoding |
| invalid_o | output | 1 | Last search found no encoding |
| imm_n_o | output | 8 | Encoded byte |
| imm_rot_o | output | 4 | Encoded rotate count (rotation = 2 × count) |
| dec_field_i | input | 12 | Field to decode: [11:8] rotate count, [7:0] byte |
| dec_value_o | output | 32 | Decoded 32-bit value |

## Verification
The bench builds the block with its default 32-bit word, 8-bit byte and 4-bit rotate count. These defaults make the full 16-candidate scan, and the wrap-around rotations at counts 12 and 15, reachable with ordinary constants. The worst-case invalid latency and the smallest-count preference can then be measured cycle by cycle against a reference encoder in the bench. Mixed pseudo-random constants, half of them built as rotated bytes, exercise both outcomes in a single run.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/rot_imm_rst_sync.sv
module rot_imm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rot_imm_cand.sv
// Tests one rotate count: the constant rotated left by twice the count
// must fit in the low byte.
module rot_imm_cand #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              hit_o,
  output logic [VAL_W-1:0]  n_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     sh;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rotl;

  always_comb begin
    sh    = SH_W'((32'(rot_i) * 2) % DATA_W);
    dbl   = {value_i, value_i} << sh;
    rotl  = dbl[2*DATA_W-1 -: DATA_W];
    hit_o = ~|rotl[DATA_W-1:VAL_W];
    n_o   = rotl[VAL_W-1:0];
  end
endmodule

// File: rtl/rot_imm_decode.sv
module rot_imm_decode #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [ROT_W+VAL_W-1:0] field_i,
  output logic [DATA_W-1:0]      value_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     sh;
  logic [DATA_W-1:0]   ext;
  logic [2*DATA_W-1:0] dbl;

  always_comb begin
    sh      = SH_W'((32'(field_i[ROT_W+VAL_W-1:VAL_W]) * 2) % DATA_W);
    ext     = DATA_W'(field_i[VAL_W-1:0]);
    dbl     = {ext, ext} >> sh;
    value_o = dbl[DATA_W-1:0];
  end
endmodule

// File: rtl/rot_imm_search.sv
module rot_imm_search #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              invalid_o,
  output logic [VAL_W-1:0]  n_o,
  output logic [ROT_W-1:0]  rot_o
);
  import rot_imm_pkg::*;

  localparam logic [ROT_W-1:0] ROT_LAST = {ROT_W{1'b1}};

  scan_state_e      state_q, state_d;
  logic [ROT_W-1:0] try_q, try_d;
  logic             done_q, done_d;
  logic             valid_q, valid_d;
  logic             invalid_q, invalid_d;
  logic [VAL_W-1:0] n_q, n_d;
  logic [ROT_W-1:0] rot_q, rot_d;
  logic             cand_hit;
  logic [VAL_W-1:0] cand_n;

  rot_imm_cand #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) cand_i (
    .value_i (value_i),
    .rot_i   (try_q),
    .hit_o   (cand_hit),
    .n_o     (cand_n)
  );

  always_comb begin
    state_d   = state_q;
    try_d     = try_q;
    done_d    = 1'b0;
    valid_d   = valid_q;
    invalid_d = invalid_q;
    n_d       = n_q;
    rot_d     = rot_q;
    unique case (state_q)
      SCAN_IDLE: begin
        if (accept_i) begin
          state_d   = SCAN_RUN;
          try_d     = '0;
          valid_d   = 1'b0;
          invalid_d = 1'b0;
        end
      end
      SCAN_RUN: begin
        if (cand_hit) begin
          state_d = SCAN_IDLE;
          done_d  = 1'b1;
          valid_d = 1'b1;
          n_d     = cand_n;
          rot_d   = try_q;
        end else if (try_q == ROT_LAST) begin
          state_d   = SCAN_IDLE;
          done_d    = 1'b1;
          invalid_d = 1'b1;
          n_d       = '0;
          rot_d     = '0;
        end else begin
          try_d = try_q + 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SCAN_IDLE;
      try_q     <= '0;
      done_q    <= 1'b0;
      valid_q   <= 1'b0;
      invalid_q <= 1'b0;
      n_q       <= '0;
      rot_q     <= '0;
    end else begin
      state_q   <= state_d;
      try_q     <= try_d;
      done_q    <= done_d;
      valid_q   <= valid_d;
      invalid_q <= invalid_d;
      n_q       <= n_d;
      rot_q     <= rot_d;
    end
  end

  assign busy_o    = (state_q == SCAN_RUN);
  assign done_o    = done_q;
  assign valid_o   = valid_q;
  assign invalid_o = invalid_q;
  assign n_o       = n_q;
  assign rot_o     = rot_q;
endmodule

// File: rtl/rot_imm_encoder.sv
module rot_imm_encoder #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [DATA_W-1:0]      value_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   valid_o,
  output logic                   invalid_o,
  output logic [VAL_W-1:0]       imm_n_o,
  output logic [ROT_W-1:0]       imm_rot_o,
  input  logic [ROT_W+VAL_W-1:0] dec_field_i,
  output logic [DATA_W-1:0]      dec_value_o
);
  logic              rst_sync_n;
  logic              accept;
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] value_d;

  rot_imm_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept  = start_i && !busy_o;
  assign value_d = accept ? value_i : value_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) value_q <= '0;
    else             value_q <= value_d;
  end

  rot_imm_search #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) search_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept_i  (accept),
    .value_i   (value_q),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .invalid_o (invalid_o),
    .n_o       (imm_n_o),
    .rot_o     (imm_rot_o)
  );

  rot_imm_decode #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) decode_i (
    .field_i (dec_field_i),
    .value_o (dec_value_o)
  );
endmodule

// File: rtl/rot_imm_encoder_chk.sv
module rot_imm_encoder_chk #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   valid_o,
  input logic                   invalid_o,
  input logic [VAL_W-1:0]       imm_n_o,
  input logic [ROT_W-1:0]       imm_rot_o,
  input logic [DATA_W-1:0]      value_q,
  input logic [ROT_W+VAL_W-1:0] dec_field_i,
  input logic [DATA_W-1:0]      dec_value_o
);
  localparam int NUM_ROT = 2 ** ROT_W;

  logic [ROT_W+1:0]  scan_cnt;
  logic [DATA_W-1:0] back_val;
  logic [DATA_W-1:0] dec_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scan_cnt <= '0;
    else if (busy_o) scan_cnt <= scan_cnt + 1'b1;
    else             scan_cnt <= '0;
  end

  function automatic logic [DATA_W-1:0] ror_ref(input logic [VAL_W-1:0] b,
                                                input logic [ROT_W-1:0] c);
    int s;
    logic [DATA_W-1:0] e;
    s = (int'(c) * 2) % DATA_W;
    e = DATA_W'(b);
    return (e >> s) | (e << (DATA_W - s));
  endfunction

  assign back_val = ror_ref(imm_n_o, imm_rot_o);
  assign dec_ref  = ror_ref(dec_field_i[VAL_W-1:0], dec_field_i[ROT_W+VAL_W-1:VAL_W]);

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !valid_o && !invalid_o));

  a_r2_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (back_val == value_q));

  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o && value_q == '0) |-> (imm_n_o == '0 && imm_rot_o == '0));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_max_scan: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan_cnt) <= NUM_ROT);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && invalid_o));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(valid_o) && $stable(invalid_o) &&
                               $stable(imm_n_o) && $stable(imm_rot_o)));

  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(value_q));

  always_comb begin
    a_r9_decode: assert (dec_value_o == dec_ref);
  end
endmodule

bind rot_imm_encoder rot_imm_encoder_chk #(
  .DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .valid_o     (valid_o),
  .invalid_o   (invalid_o),
  .imm_n_o     (imm_n_o),
  .imm_rot_o   (imm_rot_o),
  .value_q     (value_q),
  .dec_field_i (dec_field_i),
  .dec_value_o (dec_value_o)
);

// File: tb/rot_imm_encoder_tb_top.sv
module rot_imm_encoder_tb_top;
  typedef struct {
    logic       ok;
    logic [7:0] n;
    logic [3:0] r;
    int         lat;
    string      tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] value_i;
  logic        busy_o, done_o, valid_o, invalid_o;
  logic [7:0]  imm_n_o;
  logic [3:0]  imm_rot_o;
  logic [11:0] dec_field_i;
  logic [31:0] dec_value_o;

  int   errors = 0;
  int   checks = 0;
  int   busy_cnt = 0;
  int   dones = 0;
  exp_t exp_q[$];

  rot_imm_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .invalid_o(invalid_o),
    .imm_n_o(imm_n_o), .imm_rot_o(imm_rot_o),
    .dec_field_i(dec_field_i), .dec_value_o(dec_value_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic exp_t ref_enc(input logic [31:0] v, input string tag);
    exp_t e;
    e.ok = 1'b0; e.n = '0; e.r = '0; e.lat = 16; e.tag = tag;
    for (int r = 15; r >= 0; r--) begin
      logic [31:0] rl;
      rl = (r == 0) ? v : ((v << (2 * r)) | (v >> (32 - 2 * r)));
      if (rl[31:8] == '0) begin
        e.ok = 1'b1; e.n = rl[7:0]; e.r = 4'(r); e.lat = r + 1;
      end
    end
    return e;
  endfunction

  // Driver: push expectation, pulse start, wait for completion.
  task automatic run(input logic [31:0] v, input exp_t e);
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b1; value_i = v;
    @(negedge clk);
    start_i = 1'b0;
    check({"R1 busy after start ", e.tag}, {31'd0, busy_o}, 32'd1);
    check({"R1 flags cleared ", e.tag}, {30'd0, valid_o, invalid_o}, 32'd0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic ok, input logic [7:0] n,
                              input logic [3:0] r, input string tag);
    exp_t e;
    e.ok = ok; e.n = n; e.r = r; e.lat = ok ? int'(r) + 1 : 16; e.tag = tag;
    return e;
  endfunction

  // Monitor: compares each done against the oldest expectation.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_cnt++;
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({"R2 valid ", e.tag}, {31'd0, valid_o}, {31'd0, e.ok});
          check({"R5 invalid ", e.tag}, {31'd0, invalid_o}, {31'd0, !e.ok});
          check({"R3 byte ", e.tag}, {24'd0, imm_n_o}, {24'd0, e.n});
          check({"R3 rot ", e.tag}, {28'd0, imm_rot_o}, {28'd0, e.r});
          check({"R6 latency ", e.tag}, busy_cnt, e.lat);
        end
        busy_cnt = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] lcg;
    logic [7:0]  hn;
    logic [3:0]  hr;
    rst_n = 1'b0; start_i = 1'b0; value_i = '0; dec_field_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset flags", {28'd0, busy_o, done_o, valid_o, invalid_o}, 32'd0);
    check("R10 reset fields", {20'd0, imm_rot_o, imm_n_o}, 32'd0);

    run(32'd0,          mk(1'b1, 8'd0,   4'd0,  "zero R4"));
    run(32'd256,        mk(1'b1, 8'd1,   4'd12, "256 R5"));
    run(32'd484,        mk(1'b1, 8'd121, 4'd15, "484 R5"));
    run(32'h0600_0000,  mk(1'b1, 8'd6,   4'd4,  "0x06000000 R2"));
    run(32'd511,        mk(1'b0, 8'd0,   4'd0,  "511 R5"));
    run(32'd370,        mk(1'b0, 8'd0,   4'd0,  "370 R5"));
    run(32'h0601_0000,  mk(1'b0, 8'd0,   4'd0,  "0x06010000 R5"));
    run(32'hC000_0000,  mk(1'b1, 8'd3,   4'd1,  "0xC0000000 R3"));
    run(32'd3,          mk(1'b1, 8'd3,   4'd0,  "3 R3"));
    run(32'hFFFF_FFFF,  mk(1'b0, 8'd0,   4'd0,  "all-ones R5"));

    // R8: a second start during the search must be ignored.
    exp_q.push_back(mk(1'b1, 8'd1, 4'd12, "ignore R8"));
    dones = 0;
    @(negedge clk); start_i = 1'b1; value_i = 32'd256;
    @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1; value_i = 32'd3;
    @(negedge clk); start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R8 single done", dones, 1);
    check("R6 pulse ended", {31'd0, done_o}, 32'd0);
    // R7: result held while idle.
    check("R7 hold valid", {30'd0, valid_o, invalid_o}, 32'd2);
    check("R7 hold fields", {20'd0, imm_rot_o, imm_n_o}, {20'd0, 4'd12, 8'd1});

    // Mixed sweep against the reference encoder.
    lcg = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] v;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      hn = lcg[15:8]; hr = lcg[27:24];
      if (k % 2 == 0) v = (hr == 0) ? {24'd0, hn} :
                          (({24'd0, hn} >> (2 * hr)) | ({24'd0, hn} << (32 - 2 * hr)));
      else            v = lcg;
      run(v, ref_enc(v, "sweep R2"));
    end

    // R9: combinational decoder.
    dec_field_i = {4'd12, 8'd1};   #1 check("R9 decode 256", dec_value_o, 32'd256);
    dec_field_i = {4'd15, 8'd121}; #1 check("R9 decode 484", dec_value_o, 32'd484);
    dec_field_i = {4'd4, 8'd6};    #1 check("R9 decode 0x06000000", dec_value_o, 32'h0600_0000);
    dec_field_i = {4'd0, 8'hFF};   #1 check("R9 decode 0xFF", dec_value_o, 32'h0000_00FF);
    dec_field_i = {4'd1, 8'h03};   #1 check("R9 decode 0xC0000000", dec_value_o, 32'hC000_0000);

    report();
  end
endmodule